// File: doc/BRIEF.md
# Switch Port Packet Routing Decoder

This block sits behind one ingress port of a four-port packet switch. The switch is organised as two levels of virtual bridges: one upstream bridge (port 0) above three downstream bridges (ports 1 to 3). Enumeration software programs each downstream bridge with a memory window, an I/O window and a bus-number range. The windows of different ports never overlap.

For every parsed packet header the decoder picks the one egress port the packet must leave by. It uses one of two lookups, depending on the packet kind. Memory and I/O requests are looked up by their address against the windows. Completions and ID-routed messages are looked up by the bus field of their destination ID against the bus ranges. A packet that no downstream bridge claims goes to the upstream port if it entered on a downstream port. If it entered on the upstream port, it is flagged as an unsupported request.

The decision is registered and appears one clock after the header is presented. The requester ID travels alongside the decision and is never altered. Which port the instance serves is fixed by a parameter.

Top module: `vbridge_route_dec`

## Requirements
- R1: Each output is registered. `out_valid` in a cycle equals `hdr_valid` of the previous cycle. While `rst_n` is low, `out_valid`, `out_port` and `out_ur` are all zero.
- R2: Kind 2'd0 is a memory request and kind 2'd1 is an I/O request. Both are matched by `hdr_addr` against the inclusive windows [base, limit] of downstream ports 1 to 3. For these kinds, `hdr_dest_bus` has no effect.
- R3: Kind 2'd2 is a completion and kind 2'd3 is an ID-routed message. Both are matched by `hdr_dest_bus` against the inclusive ranges [lo, hi] of downstream ports 1 to 3. For these kinds, `hdr_addr` has no effect.
- R4: On a downstream-port instance (INGRESS 1 to 3), a packet that no other downstream port claims leaves by port 0: `out_port` = 4'b0001 and `out_ur` = 0.
- R5: On the upstream-port instance (INGRESS 0), a packet that no downstream port claims raises `out_ur` and leaves `out_port` at zero.
- R6: A packet is never routed to its own ingress port. A packet that falls in the ingress port's own window or bus range raises `out_ur`.
- R7: `out_req_id` equals `hdr_req_id` of the previous cycle, unchanged.
- R8: When `out_valid` is high and `out_ur` is low, `out_port` has exactly one bit set, where bit n selects port n. At any other time `out_port` is zero.
- R9: A window or range whose base is above its limit claims nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Header fields are valid this cycle |
| hdr_kind | input | 2 | Packet kind: 0 memory, 1 I/O, 2 completion, 3 ID message |
| hdr_addr | input | AW (32) | Request address |
| hdr_dest_bus | input | BW (8) | Bus field of the destination ID |
| hdr_req_id | input | RIDW (16) | Requester ID |
| cfg_mem_base | input | 3*AW | Memory window bases; port d at bits [(d-1)*AW +: AW] |
| cfg_mem_limit | input | 3*AW | Memory window limits, same packing |
| cfg_io_base | input | 3*AW | I/O window bases, same packing |
| cfg_io_limit | input | 3*AW | I/O window limits, same packing |
| cfg_bus_lo | input | 3*BW | Lowest bus number per downstream port |
| cfg_bus_hi | input | 3*BW | Highest bus number per downstream port |
| out_valid | output | 1 | Decision valid |
| out_port | output | 4 | One-hot egress port |
| out_ur | output | 1 | Unsupported-request flag |
| out_req_id | output | RIDW (16) | Requester ID, passed through unchanged |

## Verification
The assertions hold on every cycle for the shape of the decision: the one-cycle valid delay, the unchanged requester ID, a one-hot or empty egress vector, no egress vector alongside an unsupported flag, and never the instance's own port. Only the bench's scenarios can show that the chosen port is the right one. For that, the bench drives one table of headers into an upstream instance and a downstream instance at the same time. The table covers window edges, a disabled window, own-window hits and fields that a given kind must ignore.

// File: rtl/vbridge_route_dec.sv
module vbridge_route_dec #(
  parameter int NPORT   = 4,
  parameter int AW      = 32,
  parameter int BW      = 8,
  parameter int RIDW    = 16,
  parameter int INGRESS = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hdr_valid,
  input  logic [1:0]                hdr_kind,
  input  logic [AW-1:0]             hdr_addr,
  input  logic [BW-1:0]             hdr_dest_bus,
  input  logic [RIDW-1:0]           hdr_req_id,
  input  logic [(NPORT-1)*AW-1:0]   cfg_mem_base,
  input  logic [(NPORT-1)*AW-1:0]   cfg_mem_limit,
  input  logic [(NPORT-1)*AW-1:0]   cfg_io_base,
  input  logic [(NPORT-1)*AW-1:0]   cfg_io_limit,
  input  logic [(NPORT-1)*BW-1:0]   cfg_bus_lo,
  input  logic [(NPORT-1)*BW-1:0]   cfg_bus_hi,
  output logic                      out_valid,
  output logic [NPORT-1:0]          out_port,
  output logic                      out_ur,
  output logic [RIDW-1:0]           out_req_id
);
  localparam int ND = NPORT - 1;
  localparam logic [NPORT-1:0] SELF = NPORT'(1) << INGRESS;
  localparam logic [NPORT-1:0] UPSTREAM = NPORT'(1);

  logic [ND-1:0]    hit;
  logic [NPORT-1:0] claim, fwd, pick, nxt_port;
  logic             own_hit, nxt_ur;

  // R2, R3, R9: per downstream port window / bus range match
  genvar d;
  generate
    for (d = 0; d < ND; d++) begin : g_port
      logic [AW-1:0] mb, ml, ib, il;
      logic [BW-1:0] bl, bh;
      assign mb = cfg_mem_base [d*AW +: AW];
      assign ml = cfg_mem_limit[d*AW +: AW];
      assign ib = cfg_io_base  [d*AW +: AW];
      assign il = cfg_io_limit [d*AW +: AW];
      assign bl = cfg_bus_lo   [d*BW +: BW];
      assign bh = cfg_bus_hi   [d*BW +: BW];
      always_comb begin
        unique case (hdr_kind)
          2'd0:    hit[d] = (hdr_addr >= mb) && (hdr_addr <= ml);
          2'd1:    hit[d] = (hdr_addr >= ib) && (hdr_addr <= il);
          default: hit[d] = (hdr_dest_bus >= bl) && (hdr_dest_bus <= bh);
        endcase
      end
    end
  endgenerate

  assign claim   = {hit, 1'b0};
  assign own_hit = |(claim & SELF);
  assign fwd     = claim & ~SELF;
  assign pick    = fwd & (~fwd + NPORT'(1));

  // R4, R5, R6: fallback and self exclusion
  always_comb begin
    nxt_ur   = 1'b0;
    nxt_port = '0;
    if (own_hit)          nxt_ur   = 1'b1;
    else if (fwd != '0)   nxt_port = pick;
    else if (INGRESS == 0) nxt_ur  = 1'b1;
    else                  nxt_port = UPSTREAM;
  end

  // R1, R7, R8: registered decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_port   <= '0;
      out_ur     <= 1'b0;
      out_req_id <= '0;
    end else begin
      out_valid  <= hdr_valid;
      out_port   <= hdr_valid ? nxt_port : '0;
      out_ur     <= hdr_valid & nxt_ur;
      out_req_id <= hdr_req_id;
    end
  end
endmodule

module vbridge_route_dec_chk #(
  parameter int NPORT   = 4,
  parameter int RIDW    = 16,
  parameter int INGRESS = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic [RIDW-1:0]  hdr_req_id,
  input logic             out_valid,
  input logic [NPORT-1:0] out_port,
  input logic             out_ur,
  input logic [RIDW-1:0]  out_req_id
);
  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(hdr_valid));
  a_r7_req_id_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_req_id == $past(hdr_req_id));
  a_r8_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ur) |-> $countones(out_port) == 1);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_port == '0 && !out_ur));
  a_r5_ur_no_port: assert property (@(posedge clk) disable iff (!rst_n)
    out_ur |-> out_port == '0);
  a_r6_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    !out_port[INGRESS]);
endmodule

bind vbridge_route_dec vbridge_route_dec_chk #(.NPORT(NPORT), .RIDW(RIDW), .INGRESS(INGRESS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_req_id(hdr_req_id),
  .out_valid(out_valid), .out_port(out_port), .out_ur(out_ur), .out_req_id(out_req_id)
);

// File: tb/vbridge_route_dec_test.sv
module vbridge_route_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [1:0]  hdr_kind = '0;
  logic [31:0] hdr_addr = '0;
  logic [7:0]  hdr_dest_bus = '0;
  logic [15:0] hdr_req_id = '0;
  logic [95:0] cfg_mem_base, cfg_mem_limit, cfg_io_base, cfg_io_limit;
  logic [23:0] cfg_bus_lo, cfg_bus_hi;
  logic        up_valid, up_ur, dn_valid, dn_ur;
  logic [3:0]  up_port, dn_port;
  logic [15:0] up_rid, dn_rid;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // ports 3,2,1 ; port 3 memory window disabled (base > limit)
  assign cfg_mem_base  = {32'h4000_0000, 32'h2000_0000, 32'h1000_0000};
  assign cfg_mem_limit = {32'h3000_0000, 32'h2FFF_FFFF, 32'h1FFF_FFFF};
  assign cfg_io_base   = {32'h0000_3000, 32'h0000_2000, 32'h0000_1000};
  assign cfg_io_limit  = {32'h0000_3FFF, 32'h0000_2FFF, 32'h0000_1FFF};
  assign cfg_bus_lo    = {8'd6, 8'd5, 8'd2};
  assign cfg_bus_hi    = {8'd9, 8'd5, 8'd4};

  vbridge_route_dec #(.INGRESS(0)) uut (
    .clk, .rst_n, .hdr_valid, .hdr_kind, .hdr_addr, .hdr_dest_bus, .hdr_req_id,
    .cfg_mem_base, .cfg_mem_limit, .cfg_io_base, .cfg_io_limit, .cfg_bus_lo, .cfg_bus_hi,
    .out_valid(up_valid), .out_port(up_port), .out_ur(up_ur), .out_req_id(up_rid));

  vbridge_route_dec #(.INGRESS(2)) uut_dn (
    .clk, .rst_n, .hdr_valid, .hdr_kind, .hdr_addr, .hdr_dest_bus, .hdr_req_id,
    .cfg_mem_base, .cfg_mem_limit, .cfg_io_base, .cfg_io_limit, .cfg_bus_lo, .cfg_bus_hi,
    .out_valid(dn_valid), .out_port(dn_port), .out_ur(dn_ur), .out_req_id(dn_rid));

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [7:0]  bus;
    logic [3:0]  up_port;
    logic        up_ur;
    logic [3:0]  dn_port;
    logic        dn_ur;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h1000_0000, 8'd5,  4'b0010, 1'b0, 4'b0010, 1'b0, 4'd2}, // R2 low edge, bus ignored
    '{2'd0, 32'h1FFF_FFFF, 8'd5,  4'b0010, 1'b0, 4'b0010, 1'b0, 4'd2}, // R2 high edge
    '{2'd0, 32'h2000_0000, 8'd2,  4'b0100, 1'b0, 4'b0000, 1'b1, 4'd6}, // R6 own window on port 2
    '{2'd0, 32'h4000_0000, 8'd6,  4'b0000, 1'b1, 4'b0001, 1'b0, 4'd9}, // R9 disabled window
    '{2'd0, 32'h0000_0FFF, 8'd0,  4'b0000, 1'b1, 4'b0001, 1'b0, 4'd4}, // R4 / R5 miss
    '{2'd1, 32'h0000_3000, 8'd2,  4'b1000, 1'b0, 4'b1000, 1'b0, 4'd2}, // R2 I/O
    '{2'd1, 32'h0000_2FFF, 8'd0,  4'b0100, 1'b0, 4'b0000, 1'b1, 4'd6}, // R6 own I/O window
    '{2'd1, 32'h0000_5000, 8'd5,  4'b0000, 1'b1, 4'b0001, 1'b0, 4'd5}, // R5 miss on upstream
    '{2'd2, 32'h2000_0000, 8'd2,  4'b0010, 1'b0, 4'b0010, 1'b0, 4'd3}, // R3 addr ignored
    '{2'd2, 32'h0000_0000, 8'd4,  4'b0010, 1'b0, 4'b0010, 1'b0, 4'd3}, // R3 range top
    '{2'd3, 32'h1000_0000, 8'd5,  4'b0100, 1'b0, 4'b0000, 1'b1, 4'd6}, // R6 own bus
    '{2'd3, 32'h0000_0000, 8'd9,  4'b1000, 1'b0, 4'b1000, 1'b0, 4'd3}, // R3 message
    '{2'd2, 32'h0000_0000, 8'd10, 4'b0000, 1'b1, 4'b0001, 1'b0, 4'd4}, // R4 above ranges
    '{2'd2, 32'h0000_0000, 8'd1,  4'b0000, 1'b1, 4'b0001, 1'b0, 4'd5}  // R5 below ranges
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", {31'd0, up_valid}, 0);
    check("R1 reset port", {28'd0, up_port}, 0);
    check("R1 reset ur", {31'd0, dn_ur}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      hdr_kind = VECS[i].kind;
      hdr_addr = VECS[i].addr;
      hdr_dest_bus = VECS[i].bus;
      hdr_req_id = 16'hA000 + 16'(i);
      hdr_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d up port", VECS[i].req, i), {28'd0, up_port}, {28'd0, VECS[i].up_port});
      check($sformatf("R%0d vec%0d up ur", VECS[i].req, i), {31'd0, up_ur}, {31'd0, VECS[i].up_ur});
      check($sformatf("R%0d vec%0d dn port", VECS[i].req, i), {28'd0, dn_port}, {28'd0, VECS[i].dn_port});
      check($sformatf("R%0d vec%0d dn ur", VECS[i].req, i), {31'd0, dn_ur}, {31'd0, VECS[i].dn_ur});
      check($sformatf("R1 vec%0d valid", i), {30'd0, up_valid, dn_valid}, 32'd3);
      check($sformatf("R7 vec%0d req id", i), {up_rid, dn_rid}, {2{16'hA000 + 16'(i)}});
    end

    // R1 / R8: matching header with valid low gives an idle output
    hdr_valid = 1'b0;
    hdr_kind = 2'd0;
    hdr_addr = 32'h1000_0000;
    @(negedge clk);
    check("R1 idle valid", {30'd0, up_valid, dn_valid}, 0);
    check("R8 idle port", {24'd0, up_port, dn_port}, 0);
    check("R8 idle ur", {30'd0, up_ur, dn_ur}, 0);

    // R1: decision appears exactly one cycle after the header
    hdr_valid = 1'b1;
    hdr_req_id = 16'h5A5A;
    #1;
    check("R1 no early output", {31'd0, up_valid}, 0);
    @(negedge clk);
    hdr_valid = 1'b0;
    check("R1 one-cycle decision", {28'd0, up_port}, 32'b0010);
    check("R7 id unchanged", {16'd0, dn_rid}, 32'h5A5A);
    @(negedge clk);
    check("R1 drops after one", {31'd0, up_valid}, 0);

    // R1: reset in the middle of traffic clears outputs
    hdr_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset valid", {30'd0, up_valid, dn_valid}, 0);
    check("R1 async reset port", {24'd0, up_port, dn_port}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule